// File: doc/BRIEF.md
# Byte-Granular Payload Zero Extender and Stripper

This block holds two independent datapath units for event payloads whose length counts in whole bytes. Bytes are ordered least significant first. Byte `i` of a word occupies bits `[8*i+7 : 8*i]`.

The **extender** takes a word and a byte count and returns a full-width word. Every byte at or above the count is forced to zero, whatever the input held there. The **stripper** takes a full-width word and reports how many bytes are significant, which is the position of its highest non-zero byte plus one. Only that many low bytes then need to be sent or stored. Feeding the stripper's word and count into the extender gives back the original word exactly.

Each unit has a valid/ready handshake on its input and on its output, with one output register behind it. That register is controlled by a two-state machine:

- `ST_EMPTY`: no word is held. The input is always ready. On an accepted input the machine moves to `ST_FULL` (transition *load*).
- `ST_FULL`: a word is presented. If the output is taken and a new input arrives in the same cycle, the machine stays in `ST_FULL` and loads the new word (transition *refill*). If the output is taken with no new input, it returns to `ST_EMPTY` (transition *drain*). If the output is not taken, it stays in `ST_FULL` and holds the word (transition *stall*).

Top module: `payload_zx_pair`

## Requirements
- R1: While `ext_out_valid` is high, byte `i` of `ext_out_data` equals byte `i` of the accepted `ext_in_data` when `i < ext_in_len`, and is zero otherwise.
- R2: An extender length of 0 gives an all-zero output word.
- R3: An extender length of `NBYTES` or more, up to the largest value the length field can hold, passes the whole input word through unchanged.
- R4: `strip_out_len` equals the index of the highest non-zero byte of the accepted word, plus one, and never exceeds `NBYTES`.
- R5: An all-zero word gives `strip_out_len` = 0.
- R6: The stripper removes only leading zero bytes. Zero bytes below the highest non-zero byte are kept, and `strip_out_data` equals the accepted word.
- R7: An accepted word appears on the unit's output in the cycle after the accepting edge. With the output held ready, a unit accepts a new word every cycle.
- R8: While the output is valid and not ready, the output data and length stay stable and the unit's input ready is low.
- R9: Extending the stripper's output word with the stripper's output length reproduces the word the stripper accepted.
- R10: After reset, both output valids are low and both input readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_in_valid | input | 1 | Extender input word valid |
| ext_in_ready | output | 1 | Extender can accept a word |
| ext_in_data | input | DATA_W | Extender input word, least significant byte first |
| ext_in_len | input | LEN_W | Extender byte count |
| ext_out_valid | output | 1 | Extended word valid |
| ext_out_ready | input | 1 | Downstream takes the extended word |
| ext_out_data | output | DATA_W | Zero-filled word |
| strip_in_valid | input | 1 | Stripper input word valid |
| strip_in_ready | output | 1 | Stripper can accept a word |
| strip_in_data | input | DATA_W | Word to compress |
| strip_out_valid | output | 1 | Stripped result valid |
| strip_out_ready | input | 1 | Downstream takes the stripped result |
| strip_out_data | output | DATA_W | Word whose significant bytes sit at the bottom |
| strip_out_len | output | LEN_W | Number of significant bytes |

## Verification
The assertions rely on the input side obeying the handshake: a source may raise or drop `*_in_valid` freely, and the data it presents is only sampled on an edge where valid and ready are both high. The assertions also expect reset to be applied before the first word. The bench drives every input on the falling edge, keeps `ext_in_len` within its field width, and asserts reset for several cycles before any traffic. This leaves the stall and back-to-back cases as the only places where valid and ready interact.

// File: rtl/pzx_pkg.sv
package pzx_pkg;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } pzx_state_e;

endpackage

// File: rtl/pzx_byte_mask.sv
module pzx_byte_mask #(
    parameter int DATA_W = 512,
    localparam int NBYTES = DATA_W / 8,
    localparam int LEN_W  = $clog2(NBYTES + 1)
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [DATA_W-1:0] word_o
);

    // One keep decision per byte lane; lanes at or above the count are zeroed.
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic keep;
        assign keep = (len_i > LEN_W'(b));
        assign word_o[b*8 +: 8] = keep ? word_i[b*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/pzx_sig_count.sv
module pzx_sig_count #(
    parameter int DATA_W = 512,
    localparam int NBYTES = DATA_W / 8,
    localparam int LEN_W  = $clog2(NBYTES + 1)
) (
    input  logic [DATA_W-1:0] word_i,
    output logic [LEN_W-1:0]  len_o
);

    logic [NBYTES-1:0] lane_nz;

    for (genvar b = 0; b < NBYTES; b++) begin : g_nz
        assign lane_nz[b] = |word_i[b*8 +: 8];
    end

    // Highest non-zero lane wins; the scan climbs so the last hit is kept.
    always_comb begin
        len_o = '0;
        for (int b = 0; b < NBYTES; b++) begin
            if (lane_nz[b]) begin
                len_o = LEN_W'(b + 1);
            end
        end
    end

endmodule

// File: rtl/pzx_stage.sv
module pzx_stage
    import pzx_pkg::*;
#(
    parameter int PAY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PAY_W-1:0] in_pay,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PAY_W-1:0] out_pay
);

    pzx_state_e       state_q, state_d;
    logic [PAY_W-1:0] pay_q;
    logic             take;

    assign take = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid) state_d = ST_FULL;          // load
            ST_FULL: begin
                if (out_ready && !in_valid) state_d = ST_EMPTY;  // drain
                else                        state_d = ST_FULL;   // refill or stall
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        out_valid = (state_q == ST_FULL);
        in_ready  = (state_q == ST_EMPTY) || out_ready;
        out_pay   = pay_q;
    end

    always_ff @(posedge clk) begin
        if (take) begin
            pay_q <= in_pay;
        end
    end

    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pay)));

    a_r8_blocked_input: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    a_r7_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_pay == $past(in_pay)));

endmodule

// File: rtl/payload_zx_pair.sv
module payload_zx_pair #(
    parameter int DATA_W = 512,
    localparam int NBYTES = DATA_W / 8,
    localparam int LEN_W  = $clog2(NBYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_in_valid,
    output logic              ext_in_ready,
    input  logic [DATA_W-1:0] ext_in_data,
    input  logic [LEN_W-1:0]  ext_in_len,
    output logic              ext_out_valid,
    input  logic              ext_out_ready,
    output logic [DATA_W-1:0] ext_out_data,
    input  logic              strip_in_valid,
    output logic              strip_in_ready,
    input  logic [DATA_W-1:0] strip_in_data,
    output logic              strip_out_valid,
    input  logic              strip_out_ready,
    output logic [DATA_W-1:0] strip_out_data,
    output logic [LEN_W-1:0]  strip_out_len
);

    // Extender path: mask before the register.
    logic [DATA_W-1:0] ext_masked;

    pzx_byte_mask #(.DATA_W(DATA_W)) u_mask (
        .word_i (ext_in_data),
        .len_i  (ext_in_len),
        .word_o (ext_masked)
    );

    pzx_stage #(.PAY_W(DATA_W)) u_ext_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (ext_in_valid),
        .in_ready  (ext_in_ready),
        .in_pay    (ext_masked),
        .out_valid (ext_out_valid),
        .out_ready (ext_out_ready),
        .out_pay   (ext_out_data)
    );

    // Stripper path: count before the register, carry count with the word.
    logic [LEN_W-1:0]        sig_len;
    logic [LEN_W+DATA_W-1:0] strip_pay;

    pzx_sig_count #(.DATA_W(DATA_W)) u_count (
        .word_i (strip_in_data),
        .len_o  (sig_len)
    );

    pzx_stage #(.PAY_W(LEN_W + DATA_W)) u_strip_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (strip_in_valid),
        .in_ready  (strip_in_ready),
        .in_pay    ({sig_len, strip_in_data}),
        .out_valid (strip_out_valid),
        .out_ready (strip_out_ready),
        .out_pay   (strip_pay)
    );

    assign strip_out_len  = strip_pay[DATA_W +: LEN_W];
    assign strip_out_data = strip_pay[DATA_W-1:0];

    a_r4_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        strip_out_valid |-> (strip_out_len <= LEN_W'(NBYTES)));

    a_r4_top_lane_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (strip_out_valid && strip_out_len != '0)
            |-> (strip_out_data[(strip_out_len - 1'b1) * 8 +: 8] != 8'h00));

    a_r6_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (strip_in_valid && strip_in_ready) |=> (strip_out_data == $past(strip_in_data)));

    a_r2_zero_len_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_in_valid && ext_in_ready && ext_in_len == '0) |=> (ext_out_data == '0));

endmodule

// File: tb/payload_zx_pair_test.sv
module payload_zx_pair_test;

    localparam int DATA_W = 512;
    localparam int NBYTES = DATA_W / 8;
    localparam int LEN_W  = $clog2(NBYTES + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ext_in_valid = 1'b0;
    logic              ext_in_ready;
    logic [DATA_W-1:0] ext_in_data = '0;
    logic [LEN_W-1:0]  ext_in_len = '0;
    logic              ext_out_valid;
    logic              ext_out_ready = 1'b1;
    logic [DATA_W-1:0] ext_out_data;
    logic              strip_in_valid = 1'b0;
    logic              strip_in_ready;
    logic [DATA_W-1:0] strip_in_data = '0;
    logic              strip_out_valid;
    logic              strip_out_ready = 1'b1;
    logic [DATA_W-1:0] strip_out_data;
    logic [LEN_W-1:0]  strip_out_len;

    always #2ns clk = ~clk;

    payload_zx_pair #(.DATA_W(DATA_W)) uut (
        .clk (clk), .rst_n (rst_n),
        .ext_in_valid (ext_in_valid), .ext_in_ready (ext_in_ready),
        .ext_in_data (ext_in_data), .ext_in_len (ext_in_len),
        .ext_out_valid (ext_out_valid), .ext_out_ready (ext_out_ready),
        .ext_out_data (ext_out_data),
        .strip_in_valid (strip_in_valid), .strip_in_ready (strip_in_ready),
        .strip_in_data (strip_in_data),
        .strip_out_valid (strip_out_valid), .strip_out_ready (strip_out_ready),
        .strip_out_data (strip_out_data), .strip_out_len (strip_out_len)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // top: significant byte count of the stripper word; hole: interior lane forced to zero;
    // elen: byte count given to the extender.
    typedef struct packed {
        logic [7:0] top;
        logic [7:0] hole;
        logic [7:0] elen;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{top: 8'd0,  hole: 8'd255, elen: 8'd0},
        '{top: 8'd1,  hole: 8'd255, elen: 8'd1},
        '{top: 8'd2,  hole: 8'd0,   elen: 8'd5},
        '{top: 8'd7,  hole: 8'd3,   elen: 8'd7},
        '{top: 8'd16, hole: 8'd15,  elen: 8'd16},
        '{top: 8'd33, hole: 8'd0,   elen: 8'd32},
        '{top: 8'd63, hole: 8'd62,  elen: 8'd63},
        '{top: 8'd64, hole: 8'd10,  elen: 8'd64},
        '{top: 8'd64, hole: 8'd255, elen: 8'd100},
        '{top: 8'd40, hole: 8'd39,  elen: 8'd127}
    };

    function automatic logic [DATA_W-1:0] build_word(int top, int hole, int salt);
        logic [DATA_W-1:0] w = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (i < top) w[i*8 +: 8] = 8'((i * 37 + salt) | 1);
        end
        if (hole < top - 1) w[hole*8 +: 8] = 8'h00;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] expect_ext(logic [DATA_W-1:0] w, int len);
        logic [DATA_W-1:0] r = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (i < len) r[i*8 +: 8] = w[i*8 +: 8];
        end
        return r;
    endfunction

    task automatic check(bit ok, string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ext_apply(logic [DATA_W-1:0] w, int len, output logic [DATA_W-1:0] got);
        @(negedge clk);
        ext_in_data  = w;
        ext_in_len   = LEN_W'(len);
        ext_in_valid = 1'b1;
        @(negedge clk);
        ext_in_valid = 1'b0;
        check(ext_out_valid == 1'b1, "R7 ext valid", DATA_W'(ext_out_valid), DATA_W'(1));
        got = ext_out_data;
    endtask

    task automatic strip_apply(logic [DATA_W-1:0] w,
                               output logic [DATA_W-1:0] got, output logic [LEN_W-1:0] gl);
        @(negedge clk);
        strip_in_data  = w;
        strip_in_valid = 1'b1;
        @(negedge clk);
        strip_in_valid = 1'b0;
        check(strip_out_valid == 1'b1, "R7 strip valid", DATA_W'(strip_out_valid), DATA_W'(1));
        got = strip_out_data;
        gl  = strip_out_len;
    endtask

    initial begin
        #(4ns * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] w, got, ew, garbage, sw, rt;
        logic [LEN_W-1:0]  gl;
        garbage = {NBYTES{8'hC3}};

        repeat (4) @(negedge clk);
        // R10: reset state
        check(!ext_out_valid && !strip_out_valid, "R10 valids low after reset",
              DATA_W'({ext_out_valid, strip_out_valid}), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ext_in_ready && strip_in_ready, "R10 readies high after reset",
              DATA_W'({ext_in_ready, strip_in_ready}), DATA_W'(2'b11));

        // Vector table walk: R1, R2, R3, R4, R5, R6, R9
        for (int v = 0; v < NV; v++) begin
            int top  = int'(VECS[v].top);
            int hole = int'(VECS[v].hole);
            int elen = int'(VECS[v].elen);
            ext_apply(garbage, elen, got);
            ew = expect_ext(garbage, elen);
            check(got == ew, "R1/R2/R3 extender masking", got, ew);

            w = build_word(top, hole, v + 11);
            strip_apply(w, sw, gl);
            check(int'(gl) == top, "R4/R5 strip length", DATA_W'(gl), DATA_W'(top));
            check(sw == w, "R6 strip word kept", sw, w);

            ext_apply(sw, int'(gl), rt);
            check(rt == w, "R9 round trip", rt, w);
        end

        // R2: empty payload over non-zero data
        ext_apply({NBYTES{8'hFF}}, 0, got);
        check(got == '0, "R2 zero length", got, '0);
        // R3: length above NBYTES
        ext_apply({NBYTES{8'h5A}}, 127, got);
        check(got == {NBYTES{8'h5A}}, "R3 saturated length", got, {NBYTES{8'h5A}});
        // R5: all-zero word
        strip_apply('0, sw, gl);
        check(gl == '0, "R5 all zero length", DATA_W'(gl), '0);
        // R6: interior zeros kept; top lane 5 with lanes 1..4 zero
        w = '0;
        w[7:0] = 8'h01;
        w[5*8 +: 8] = 8'h80;
        strip_apply(w, sw, gl);
        check(gl == LEN_W'(6), "R6 interior zeros length", DATA_W'(gl), DATA_W'(6));

        // R7: back-to-back stripper words, one per cycle
        @(negedge clk);
        strip_in_valid = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            strip_in_data = build_word(k * 9, 255, k);
            @(negedge clk);
            check(strip_in_ready && strip_out_valid && strip_out_len == LEN_W'(k * 9),
                  "R7 streaming", DATA_W'(strip_out_len), DATA_W'(k * 9));
        end
        strip_in_valid = 1'b0;
        @(negedge clk);
        check(!strip_out_valid, "R7 drain", DATA_W'(strip_out_valid), '0);

        // R8: stall on extender output
        ext_out_ready = 1'b0;
        w = build_word(64, 255, 3);
        ext_in_data  = w;
        ext_in_len   = LEN_W'(64);
        ext_in_valid = 1'b1;
        @(negedge clk);
        ext_in_data = build_word(20, 255, 4);
        ext_in_len  = LEN_W'(20);
        check(!ext_in_ready, "R8 input blocked", DATA_W'(ext_in_ready), '0);
        repeat (2) @(negedge clk);
        check(ext_out_valid && ext_out_data == w, "R8 held word", ext_out_data, w);
        ext_out_ready = 1'b1;
        @(negedge clk);
        ext_in_valid = 1'b0;
        ew = build_word(20, 255, 4);
        check(ext_out_valid && ext_out_data == ew, "R8 release then next", ext_out_data, ew);

        // R8: stall on stripper output, length held
        strip_out_ready = 1'b0;
        strip_apply(build_word(12, 255, 5), sw, gl);
        repeat (2) @(negedge clk);
        check(strip_out_valid && strip_out_len == LEN_W'(12) && !strip_in_ready,
              "R8 strip held", DATA_W'(strip_out_len), DATA_W'(12));
        strip_out_ready = 1'b1;
        @(negedge clk);
        check(!strip_out_valid, "R8 strip drained", DATA_W'(strip_out_valid), '0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule